// File: doc/BRIEF.md
# Back-Porch Clamp Pulse Generator

This block produces the once-per-line clamp pulse that tells the analog front end of a video digitizer when to restore its black reference. It runs on the pixel clock. It watches the incoming horizontal sync and detects the edge that ends each sync pulse. It then waits a programmed number of pixel clocks, so that the window lands on the back porch, and holds the clamp active for a second programmed number of pixel clocks. A polarity input says which sync transition is the leading one, and the window is always timed from the opposite (trailing) one.

As an alternative, the clamp can come from a dedicated pin driven by the system. In that mode the pin is resynchronized and polarity-corrected, and the internal timing values have no influence. The block also presents the clamp target code for each colour channel. Red and blue can each be switched between the bottom of the converter range and its midpoint, which suits colour-difference signals. Green always clamps to the bottom.

Typical settings place the window 8 pixels after the sync ends and hold it for 20 pixels.

Top module: `bp_clamp_timer`

## Requirements
- R1: In internal mode (`clamp_src_ext`=0), `clamp_out` rises at the (P+3)-th rising clock edge after the first edge that samples the trailing sync transition. P is `place_cfg`, valid from 1 to 255.
- R2: In internal mode the clamp pulse stays high for exactly D consecutive clock cycles. D is `dur_cfg`, valid from 1 to 255.
- R3: With `sync_act_high`=1 the trailing transition is 1 to 0. With `sync_act_high`=0 it is 0 to 1. The leading transition on its own starts no window.
- R4: A programmed placement or duration of 0 behaves as 1.
- R5: A trailing transition that arrives while a placement or duration count is running restarts timing from the new transition. The clamp drops while the new placement runs, and the full duration follows.
- R6: In external mode (`clamp_src_ext`=1), `clamp_out` equals `ext_clamp_in` XOR `ext_clamp_act_low`, two clock edges after the first edge that samples the pin. Sync transitions, `place_cfg` and `dur_cfg` have no effect.
- R7: `red_target` is 8'h80 when `red_mid_sel`=1 and 8'h00 otherwise. `blu_target` follows `blu_mid_sel` in the same way. `grn_target` is always 8'h00.
- R8: While `rst_n` is low, `clamp_out` is 0 and no window is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| hsync_in | input | 1 | Horizontal sync, asynchronous to clk |
| ext_clamp_in | input | 1 | External clamp pin |
| sync_act_high | input | 1 | 1: sync pulse is high (trailing edge falls); 0: sync pulse is low |
| clamp_src_ext | input | 1 | 0: internal timing; 1: external pin |
| ext_clamp_act_low | input | 1 | 1: clamp while pin is low; 0: clamp while pin is high |
| place_cfg | input | 8 | Pixels from trailing sync edge to clamp start |
| dur_cfg | input | 8 | Clamp length in pixels |
| red_mid_sel | input | 1 | Red clamps to midscale when 1 |
| blu_mid_sel | input | 1 | Blue clamps to midscale when 1 |
| clamp_out | output | 1 | Registered clamp pulse, active high |
| red_target | output | 8 | Red clamp target code |
| grn_target | output | 8 | Green clamp target code |
| blu_target | output | 8 | Blue clamp target code |

## Verification
Window timing is tried with several placement and duration pairs: the typical 8/20, the extremes 1/1 and 255/255, and 0/0. The rise cycle and the pulse length separate off-by-one faults in the placement counter from those in the duration counter, and the 0/0 case shows whether zero is folded to one. Sync is driven in both polarities, with a long leading-only stretch that must produce nothing. That stretch exposes a design that times from the wrong edge. Restart cases put a second sync pulse inside the placement count and inside the clamp pulse, which shows whether a running count is reloaded or allowed to finish. External mode toggles the pin under both polarities while sync keeps pulsing, which checks both the two-cycle path and that the internal timing is ignored.

// File: rtl/bp_clamp_pkg.sv
package bp_clamp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PLACE = 2'd1,
    PH_HOLD  = 2'd2
  } clamp_phase_t;

  // Midscale code for a converter of the given width: only the top bit set.
  function automatic logic [15:0] midscale_code(input int width);
    logic [15:0] v;
    v = '0;
    v[width-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/bp_sync_edge.sv
module bp_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic trail_is_fall,
  output logic trail_pulse
);
  localparam int CHAIN_LEN = SYNC_STAGES + 1;

  logic [CHAIN_LEN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar g = 1; g < CHAIN_LEN; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  logic cur_lvl, prev_lvl;
  assign cur_lvl  = chain_q[SYNC_STAGES-1];
  assign prev_lvl = chain_q[SYNC_STAGES];

  assign trail_pulse = trail_is_fall ? (prev_lvl & ~cur_lvl)
                                     : (~prev_lvl & cur_lvl);
endmodule

// File: rtl/bp_clamp_window.sv
module bp_clamp_window
  import bp_clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trail_pulse,
  input  logic [CNT_W-1:0] place_cfg,
  input  logic [CNT_W-1:0] dur_cfg,
  output logic             win_active,
  output logic             placing
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // A programmed zero is folded to one.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  clamp_phase_t     phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (trail_pulse) begin
      phase_q <= PH_PLACE;
      cnt_q   <= eff_count(place_cfg);
    end else begin
      case (phase_q)
        PH_PLACE: begin
          if (cnt_q == ONE) begin
            phase_q <= PH_HOLD;
            cnt_q   <= eff_count(dur_cfg);
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        PH_HOLD: begin
          if (cnt_q == ONE) phase_q <= PH_IDLE;
          else              cnt_q   <= cnt_q - ONE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign win_active = (phase_q == PH_HOLD);
  assign placing    = (phase_q == PH_PLACE);
endmodule

// File: rtl/bp_ext_clamp.sv
module bp_ext_clamp #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic act_low,
  output logic ext_act
);
  logic [SYNC_STAGES-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q[0] <= 1'b0;
    else        pin_q[0] <= pin_in;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q[g] <= 1'b0;
      else        pin_q[g] <= pin_q[g-1];
    end
  end

  assign ext_act = pin_q[SYNC_STAGES-1] ^ act_low;
endmodule

// File: rtl/bp_clamp_timer.sv
module bp_clamp_timer
  import bp_clamp_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              ext_clamp_in,
  input  logic              sync_act_high,
  input  logic              clamp_src_ext,
  input  logic              ext_clamp_act_low,
  input  logic [CNT_W-1:0]  place_cfg,
  input  logic [CNT_W-1:0]  dur_cfg,
  input  logic              red_mid_sel,
  input  logic              blu_mid_sel,
  output logic              clamp_out,
  output logic [CODE_W-1:0] red_target,
  output logic [CODE_W-1:0] grn_target,
  output logic [CODE_W-1:0] blu_target
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(midscale_code(CODE_W));

  function automatic logic [CODE_W-1:0] target_code(input logic mid_sel);
    return mid_sel ? MID_CODE : '0;
  endfunction

  // Named internal events, observed by the bound checker.
  logic trail_pulse;
  logic win_active;
  logic placing;
  logic ext_act;

  bp_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk           (clk),
    .rst_n         (rst_n),
    .async_in      (hsync_in),
    .trail_is_fall (sync_act_high),
    .trail_pulse   (trail_pulse)
  );

  bp_clamp_window #(.CNT_W(CNT_W)) u_win (
    .clk         (clk),
    .rst_n       (rst_n),
    .trail_pulse (trail_pulse),
    .place_cfg   (place_cfg),
    .dur_cfg     (dur_cfg),
    .win_active  (win_active),
    .placing     (placing)
  );

  bp_ext_clamp #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (ext_clamp_in),
    .act_low (ext_clamp_act_low),
    .ext_act (ext_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clamp_out <= 1'b0;
    else        clamp_out <= clamp_src_ext ? ext_act : win_active;
  end

  assign red_target = target_code(red_mid_sel);
  assign blu_target = target_code(blu_mid_sel);
  assign grn_target = '0;
endmodule

// File: rtl/bp_clamp_timer_chk.sv
module bp_clamp_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trail_pulse,
  input logic             win_active,
  input logic             placing,
  input logic             ext_act,
  input logic             clamp_src_ext,
  input logic             clamp_out,
  input logic [CNT_W-1:0] dur_cfg
);
  logic [CNT_W:0] run_len;
  logic           armed;
  logic [CNT_W:0] dur_eff;

  assign dur_eff = (dur_cfg == '0) ? (CNT_W+1)'(1) : {1'b0, dur_cfg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
      armed   <= 1'b0;
    end else begin
      run_len <= win_active ? run_len + 1'b1 : '0;
      armed   <= 1'b1;
    end
  end

  // R1: a clamp window opens only out of the placement phase
  assert_start_after_place_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_active) |-> $past(placing));

  // R2: the window never outlasts the programmed duration
  assert_dur_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |-> (run_len < dur_eff));

  // R5: every trailing edge reloads the placement count
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trail_pulse |=> placing);

  // R6: in external mode the output follows the corrected pin one cycle later
  assert_ext_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clamp_src_ext && $past(clamp_src_ext)) |-> (clamp_out == $past(ext_act)));

  // R8: output low while reset is held
  always @(posedge clk) begin
    if (!rst_n) assert_reset_low_R8: assert (!clamp_out);
  end
endmodule

bind bp_clamp_timer bp_clamp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .trail_pulse   (trail_pulse),
  .win_active    (win_active),
  .placing       (placing),
  .ext_act       (ext_act),
  .clamp_src_ext (clamp_src_ext),
  .clamp_out     (clamp_out),
  .dur_cfg       (dur_cfg)
);

// File: tb/bp_clamp_timer_bench.sv
`timescale 1ns/1ps
module bp_clamp_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_in = 1'b0;
  logic       ext_clamp_in = 1'b1;
  logic       sync_act_high = 1'b1;
  logic       clamp_src_ext = 1'b0;
  logic       ext_clamp_act_low = 1'b1;
  logic [7:0] place_cfg = 8'd8;
  logic [7:0] dur_cfg = 8'd20;
  logic       red_mid_sel = 1'b0;
  logic       blu_mid_sel = 1'b0;
  logic       clamp_out;
  logic [7:0] red_target, grn_target, blu_target;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic trace [1:700];

  always #4 clk = ~clk;

  bp_clamp_timer u_bp_clamp_timer (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .ext_clamp_in(ext_clamp_in),
    .sync_act_high(sync_act_high), .clamp_src_ext(clamp_src_ext),
    .ext_clamp_act_low(ext_clamp_act_low), .place_cfg(place_cfg), .dur_cfg(dur_cfg),
    .red_mid_sel(red_mid_sel), .blu_mid_sel(blu_mid_sel), .clamp_out(clamp_out),
    .red_target(red_target), .grn_target(grn_target), .blu_target(blu_target)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_sync(input logic v);
    @(negedge clk);
    hsync_in = v;
  endtask

  task automatic capture(input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      trace[i] = clamp_out;
    end
  endtask

  function automatic int first_high(input int from, input int n);
    for (int i = from; i <= n; i++) if (trace[i]) return i;
    return 0;
  endfunction

  function automatic int run_from(input int from, input int n);
    int c = 0;
    for (int i = from; i <= n; i++) begin
      if (!trace[i]) break;
      c++;
    end
    return c;
  endfunction

  // Expected: high from sample P+4 (sample 1 follows the first edge that sees the change)
  task automatic window_case(input int p, input int d, input string req);
    int pe, de, f;
    pe = (p == 0) ? 1 : p;
    de = (d == 0) ? 1 : d;
    place_cfg = 8'(p);
    dur_cfg = 8'(d);
    drive_sync(1'b1);
    capture(4);
    drive_sync(1'b0);
    capture(pe + de + 20);
    f = first_high(1, pe + de + 20);
    chk(f == pe + 4, {req, " rise"}, f, pe + 4);
    chk(run_from(f, pe + de + 20) == de, {req, " length"}, run_from(f, pe + de + 20), de);
  endtask

  task automatic t_reset_r8;
    chk(clamp_out == 1'b0, "R8 clamp in reset", clamp_out, 0);
    @(negedge clk);
    rst_n = 1'b1;
    capture(30);
    chk(first_high(1, 30) == 0, "R8 idle after reset", first_high(1, 30), 0);
  endtask

  task automatic t_basic_r1_r2_r3;
    place_cfg = 8'd8;
    dur_cfg = 8'd20;
    drive_sync(1'b1);
    capture(60);
    chk(first_high(1, 60) == 0, "R3 leading edge only", first_high(1, 60), 0);
    drive_sync(1'b0);
    capture(60);
    chk(first_high(1, 60) == 12, "R1 rise P=8", first_high(1, 60), 12);
    chk(run_from(12, 60) == 20, "R2 length D=20", run_from(12, 60), 20);
  endtask

  task automatic t_bounds_r1_r2_r4;
    window_case(1, 1, "R1 R2 P=1 D=1");
    window_case(255, 255, "R1 R2 P=255 D=255");
    window_case(0, 0, "R4 zero as one");
    window_case(3, 0, "R4 zero duration");
  endtask

  task automatic t_act_low_r3;
    sync_act_high = 1'b0;
    place_cfg = 8'd3;
    dur_cfg = 8'd5;
    drive_sync(1'b1);
    capture(40);
    drive_sync(1'b0);
    capture(60);
    chk(first_high(1, 60) == 0, "R3 low-active leading", first_high(1, 60), 0);
    drive_sync(1'b1);
    capture(30);
    chk(first_high(1, 30) == 7, "R3 low-active rise", first_high(1, 30), 7);
    chk(run_from(7, 30) == 5, "R3 low-active length", run_from(7, 30), 5);
    sync_act_high = 1'b1;
    drive_sync(1'b0);
    capture(40);
  endtask

  task automatic t_restart_r5;
    place_cfg = 8'd10;
    dur_cfg = 8'd10;
    drive_sync(1'b1);
    capture(3);
    drive_sync(1'b0);
    capture(3);
    chk(first_high(1, 3) == 0, "R5 no early clamp", first_high(1, 3), 0);
    drive_sync(1'b1);
    drive_sync(1'b0);
    capture(40);
    chk(first_high(1, 40) == 14, "R5 restart in placement", first_high(1, 40), 14);
    chk(run_from(14, 40) == 10, "R5 length after restart", run_from(14, 40), 10);
    place_cfg = 8'd2;
    dur_cfg = 8'd20;
    drive_sync(1'b1);
    drive_sync(1'b0);
    capture(10);
    chk(trace[6] == 1'b1 && trace[10] == 1'b1, "R5 first pulse up", trace[10], 1);
    drive_sync(1'b1);
    drive_sync(1'b0);
    capture(40);
    chk(trace[3] == 1'b1, "R5 held until reload", trace[3], 1);
    chk(trace[4] == 1'b0 && trace[5] == 1'b0, "R5 drop during new placement", trace[4], 0);
    chk(run_from(6, 40) == 20, "R5 full duration after restart", run_from(6, 40), 20);
  endtask

  task automatic t_external_r6;
    clamp_src_ext = 1'b1;
    ext_clamp_act_low = 1'b1;
    ext_clamp_in = 1'b1;
    capture(5);
    chk(trace[5] == 1'b0, "R6 pin high inactive", trace[5], 0);
    @(negedge clk);
    ext_clamp_in = 1'b0;
    capture(4);
    chk(trace[2] == 1'b0 && trace[3] == 1'b1, "R6 latency two edges", trace[3], 1);
    @(negedge clk);
    ext_clamp_in = 1'b1;
    place_cfg = 8'd4;
    dur_cfg = 8'd6;
    drive_sync(1'b1);
    drive_sync(1'b0);
    capture(40);
    chk(first_high(4, 40) == 0, "R6 sync ignored", first_high(4, 40), 0);
    ext_clamp_act_low = 1'b0;
    capture(4);
    chk(trace[3] == 1'b1, "R6 high-active pin", trace[3], 1);
    @(negedge clk);
    ext_clamp_in = 1'b0;
    capture(4);
    chk(trace[3] == 1'b0, "R6 high-active release", trace[3], 0);
    clamp_src_ext = 1'b0;
    ext_clamp_act_low = 1'b1;
    capture(20);
  endtask

  task automatic t_targets_r7;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      red_mid_sel = k[0];
      blu_mid_sel = k[1];
      #1;
      chk(red_target == (k[0] ? 8'h80 : 8'h00), "R7 red target", red_target, k[0] ? 128 : 0);
      chk(blu_target == (k[1] ? 8'h80 : 8'h00), "R7 blue target", blu_target, k[1] ? 128 : 0);
      chk(grn_target == 8'h00, "R7 green target", grn_target, 0);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset_r8();
    t_basic_r1_r2_r3();
    t_bounds_r1_r2_r4();
    t_act_low_r3();
    t_restart_r5();
    t_external_r6();
    t_targets_r7();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule